// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block records the time of a network packet event so that software can match the time to its packet. There are two capture units, one for received packets and one for transmitted packets. When a unit is enabled and an event strobe arrives, it copies the free-running time-counter value from that same cycle. The unit then holds the value until software collects it.

Software sees each direction as three 32-bit registers on a simple read/write port: a control word, the low half of the stamp and the high half of the stamp. After a capture the unit locks. Any later event is dropped and recorded as an overrun. Reading the high half frees the unit. Because each direction can hold only one stamp at a time, software always knows which packet a stamp belongs to. At setup, software reads all four stamp registers to throw away any leftover capture.

Top module: `ts_capture_latch`

## Requirements
- R1: After reset, every control word reads 0 (enable off, valid clear, overrun clear) and every stamp register reads 0.
- R2: Control bit 0 is the capture enable. A write to a control word sets it from write data bit 0, and a read of the control word returns it. Register address map: bit 2 selects the direction (0 receive, 1 transmit); bits 1:0 select the register (0 control, 1 stamp low, 2 stamp high, 3 reads 0).
- R3: While a direction's enable is 0, its event strobes are ignored. Valid stays 0 and the stamp registers keep their old value.
- R4: An event on an enabled, unlocked direction stores the time value present in the same clock cycle. The low 32 bits go to the stamp-low register and the high 32 bits go to the stamp-high register. Control bit 1 (valid) reads 1 from the next cycle.
- R5: While valid is 1, further events leave both stamp registers unchanged.
- R6: A read of stamp-high returns the held value and clears valid. A read of stamp-low clears nothing.
- R7: If an event and a stamp-high read fall in the same cycle, the read returns the old stamp. The new event is then captured and valid stays 1.
- R8: Control bit 2 (overrun) is set when an enabled event is dropped because the unit is locked. A control read clears it. If a drop and a control read fall in the same cycle, the bit stays set.
- R9: The two directions are independent. Events, enables and reads on one direction do not alter the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 64 | Free-running time-counter value |
| rx_evt | input | 1 | Receive event strobe, one cycle |
| tx_evt | input | 1 | Transmit event strobe, one cycle |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_rd |

## Verification
Capture is driven with distinct time values for each event. A stamp taken in the wrong cycle, or with its halves swapped, therefore shows up as a wrong value. Events arrive in four situations:
- unlocked, to show a capture;
- locked, to show the lock and the overrun flag;
- with the enable off, to show the event is ignored;
- in the same cycle as a stamp-high read, to show the read is honoured before the new capture.

Stamp-low and stamp-high reads are interleaved to show that only the high read frees the unit. Activity on the transmit side while receive holds a stamp shows that the two directions are separate.

// File: rtl/ts_latch_pkg.sv
package ts_latch_pkg;

    localparam int NUM_DIR   = 2;
    localparam int DIR_RX    = 0;
    localparam int DIR_TX    = 1;
    localparam int ADDR_W    = 3;

    // register select within a direction (addr[1:0])
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_LO   = 2'd1;
    localparam logic [1:0] SEL_HI   = 2'd2;

    // control word bit positions
    localparam int CB_EN  = 0;
    localparam int CB_VAL = 1;
    localparam int CB_OVR = 2;

    typedef struct packed {
        logic ctrl_rd;
        logic lo_rd;
        logic hi_rd;
        logic en_wr;
        logic en_val;
    } dir_strobe_t;

    typedef struct packed {
        logic en;
        logic valid;
        logic overrun;
    } unit_flags_t;

    function automatic logic addr_dir(input logic [ADDR_W-1:0] a);
        return a[2];
    endfunction

    function automatic logic [1:0] addr_sel(input logic [ADDR_W-1:0] a);
        return a[1:0];
    endfunction

endpackage

// File: rtl/ts_reg_decode.sv
module ts_reg_decode
    import ts_latch_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                  rd,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [WORD_W-1:0]     wdata,
    output dir_strobe_t           strobe [NUM_DIR]
);
    logic [WORD_W-1:0] unused_wdata;
    assign unused_wdata = {wdata[WORD_W-1:1], 1'b0};

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        logic hit;
        assign hit = (addr_dir(addr) == d[0]);
        always_comb begin
            strobe[d].ctrl_rd = hit && rd && (addr_sel(addr) == SEL_CTRL);
            strobe[d].lo_rd   = hit && rd && (addr_sel(addr) == SEL_LO);
            strobe[d].hi_rd   = hit && rd && (addr_sel(addr) == SEL_HI);
            strobe[d].en_wr   = hit && wr && (addr_sel(addr) == SEL_CTRL);
            strobe[d].en_val  = wdata[CB_EN];
        end
    end
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
    import ts_latch_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  logic [TIME_W-1:0] time_now,
    input  dir_strobe_t       strobe,
    output unit_flags_t       flags,
    output logic [TIME_W-1:0] stamp
);
    logic held_after_read;
    logic capture;
    logic drop;

    // a releasing read frees the unit before the event in the same cycle
    assign held_after_read = flags.valid && !strobe.hi_rd;
    assign capture = evt && flags.en && !held_after_read;
    assign drop    = evt && flags.en && held_after_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            stamp <= '0;
        end else begin
            if (strobe.en_wr)
                flags.en <= strobe.en_val;
            flags.valid <= capture || held_after_read;
            if (capture)
                stamp <= time_now;
            if (drop)
                flags.overrun <= 1'b1;
            else if (strobe.ctrl_rd)
                flags.overrun <= 1'b0;
        end
    end

    // R4
    capture_takes_time_chk: assert property (@(posedge clk) disable iff (rst)
        (evt && flags.en && !flags.valid) |=> (flags.valid && stamp == $past(time_now)));

    // R5
    lock_holds_stamp_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.valid && !strobe.hi_rd) |=> ($stable(stamp) && flags.valid));

    // R3
    disabled_ignores_chk: assert property (@(posedge clk) disable iff (rst)
        (!flags.en && !flags.valid) |=> (!flags.valid && $stable(stamp)));

    // R6
    release_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe.hi_rd && !evt) |=> !flags.valid);

    // R7
    read_then_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe.hi_rd && evt && flags.en) |=> (flags.valid && stamp == $past(time_now)));

    // R8
    overrun_on_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (evt && flags.en && flags.valid && !strobe.hi_rd) |=> flags.overrun);
endmodule

// File: rtl/ts_capture_latch.sv
module ts_capture_latch
    import ts_latch_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int TIME_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] time_now,
    input  logic              rx_evt,
    input  logic              tx_evt,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata
);
    dir_strobe_t       strobe [NUM_DIR];
    unit_flags_t       flags  [NUM_DIR];
    logic [TIME_W-1:0] stamp  [NUM_DIR];
    logic [NUM_DIR-1:0] evt_vec;

    assign evt_vec[DIR_RX] = rx_evt;
    assign evt_vec[DIR_TX] = tx_evt;

    ts_reg_decode #(.WORD_W(WORD_W)) u_decode (
        .rd     (reg_rd),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .strobe (strobe)
    );

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_unit
        ts_capture_unit #(.TIME_W(TIME_W)) u_unit (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt_vec[d]),
            .time_now (time_now),
            .strobe   (strobe[d]),
            .flags    (flags[d]),
            .stamp    (stamp[d])
        );
    end

    always_comb begin
        unit_flags_t       f;
        logic [TIME_W-1:0] s;
        f = flags[addr_dir(reg_addr)];
        s = stamp[addr_dir(reg_addr)];
        reg_rdata = '0;
        case (addr_sel(reg_addr))
            SEL_CTRL: begin
                reg_rdata[CB_EN]  = f.en;
                reg_rdata[CB_VAL] = f.valid;
                reg_rdata[CB_OVR] = f.overrun;
            end
            SEL_LO:   reg_rdata = s[WORD_W-1:0];
            SEL_HI:   reg_rdata = s[TIME_W-1:WORD_W];
            default:  reg_rdata = '0;
        endcase
    end

    // R9
    dir_isolation_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_evt && !(reg_rd && !reg_addr[2] && reg_addr[1:0] == SEL_HI))
        |=> $stable(stamp[DIR_RX]));
endmodule

// File: tb/ts_capture_latch_bench.sv
module ts_capture_latch_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] time_now;
    logic        rx_evt, tx_evt, reg_rd, reg_wr;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    ts_capture_latch u_ts_capture_latch (
        .clk(clk), .rst(rst), .time_now(time_now), .rx_evt(rx_evt), .tx_evt(tx_evt),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    localparam logic [2:0] RXC = 3'd0, RXL = 3'd1, RXH = 3'd2;
    localparam logic [2:0] TXC = 3'd4, TXL = 3'd5, TXH = 3'd6;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 check(req, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic is_tx, input logic [63:0] t);
        @(negedge clk);
        time_now = t;
        if (is_tx) tx_evt = 1'b1; else rx_evt = 1'b1;
        @(negedge clk);
        rx_evt = 1'b0; tx_evt = 1'b0;
        time_now = 64'hFFFF_0000_FFFF_0000;
    endtask

    task automatic t_reset();
        rd_chk("R1", RXC, 32'd0);
        rd_chk("R1", TXC, 32'd0);
        rd_chk("R1", RXH, 32'd0);
        rd_chk("R1", TXL, 32'd0);
    endtask

    task automatic t_enable();
        wr(RXC, 32'hFFFF_FFFF);
        rd_chk("R2", RXC, 32'd1);
        wr(RXC, 32'd0);
        rd_chk("R2", RXC, 32'd0);
        wr(RXC, 32'd1);
    endtask

    task automatic t_disabled();
        pulse(1'b1, 64'h0BAD_0BAD_0BAD_0BAD);
        rd_chk("R3", TXC, 32'd0);
        rd_chk("R3", TXL, 32'd0);
        rd_chk("R3", TXH, 32'd0);
    endtask

    task automatic t_capture();
        pulse(1'b0, 64'hA1B2_C3D4_1122_3344);
        rd_chk("R4", RXC, 32'd3);
        rd_chk("R4", RXL, 32'h1122_3344);
    endtask

    task automatic t_lock();
        pulse(1'b0, 64'h5555_6666_7777_8888);
        rd_chk("R5", RXL, 32'h1122_3344);
        rd_chk("R8", RXC, 32'd7);
        rd_chk("R8", RXC, 32'd3);
    endtask

    task automatic t_release();
        rd_chk("R6", RXL, 32'h1122_3344);
        rd_chk("R6", RXC, 32'd3);
        rd_chk("R6", RXH, 32'hA1B2_C3D4);
        rd_chk("R6", RXC, 32'd1);
    endtask

    task automatic t_same_cycle();
        pulse(1'b0, 64'h0000_0011_0000_0022);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = RXH; rx_evt = 1'b1;
        time_now = 64'h0000_0033_0000_0044;
        #1 check("R7", reg_rdata, 32'h0000_0011);
        @(negedge clk);
        reg_rd = 1'b0; rx_evt = 1'b0;
        rd_chk("R7", RXC, 32'd3);
        rd_chk("R7", RXL, 32'h0000_0044);
    endtask

    task automatic t_indep();
        wr(TXC, 32'd1);
        pulse(1'b1, 64'h7000_0001_7000_0002);
        rd_chk("R9", TXC, 32'd3);
        rd_chk("R9", TXH, 32'h7000_0001);
        rd_chk("R9", RXC, 32'd3);
        rd_chk("R9", RXL, 32'h0000_0044);
        // R8 drop coincident with control read: bit stays set
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = RXC; rx_evt = 1'b1;
        #1 check("R8", reg_rdata, 32'd3);
        @(negedge clk);
        reg_rd = 1'b0; rx_evt = 1'b0;
        rd_chk("R8", RXC, 32'd7);
        rd_chk("R8", RXC, 32'd3);
    endtask

    initial begin
        rst = 1'b1; time_now = '0; rx_evt = 0; tx_evt = 0;
        reg_rd = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable();
        t_disabled();
        t_capture();
        t_lock();
        t_release();
        t_same_cycle();
        t_indep();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule